// File: doc/BRIEF.md
# Three-channel programmable interval timer

The block holds three independent 16-bit down-counters. A host reaches them through a synchronous byte bus with a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a shared control port that sets up one channel at a time.

Each channel has its own count clock, gate and output pin. The count clock and gate are sampled on the system clock, and the block acts on their rising edges. The control word picks the channel, how its count bytes are transferred, the output mode and binary or decimal (BCD) counting. A channel runs in one of six modes:

- one-shot (output goes high when the count expires)
- gate-retriggered one-shot
- periodic rate generator
- square wave
- software strobe
- gate-triggered strobe

A latch command freezes a channel's count so software can read both bytes without the value changing in between. A typical use is delay timing: software loads a one-shot count and polls the output until it goes high.

Top module: `trio_timer`

## Requirements
- R1: A write to address 3 is a control word. Bits 7:6 give the channel (00, 01 or 10); the value 11 is ignored and changes no channel. Bits 5:4 give the access command, bits 3:1 the mode and bit 0 selects binary (0) or BCD (1) counting. Reads of address 3 return 0.
- R2: Access command 01 transfers only the low byte and 10 only the high byte; for writes the other byte of the count is zero. Command 11 transfers the low byte and then the high byte. A written count is loaded on the first count-clock tick after its final byte is written, and never before.
- R3: A control word for mode 000 drives the output low, and writing a count drives it low again. The output goes high on the Nth tick after the tick that loaded count N, and gate low freezes the count. A control word for any other mode drives the output high. A control word leaves the count register unchanged.
- R4: In mode 001, a rising gate edge arms a trigger. The next tick loads N and drives the output low, and the output goes high N ticks later. A new gate rise restarts the full count.
- R5: In mode 010, the output is low only on ticks k with k mod N = N-1, where k counts ticks after the load tick. Gate low forces the output high and stops counting. A rising gate edge reloads the count on the next tick.
- R6: In mode 011, the output is high when (k mod N) < ceil(N/2) and low otherwise, so odd counts give one extra high tick. Gate behaves as in R5.
- R7: In mode 100, the output stays high except for a single low tick at k = N after the load tick. Gate low freezes the count.
- R8: In mode 101, a rising gate edge arms a trigger and the next tick loads the count. The output is low for one tick at k = N after that tick.
- R9: In BCD mode, each 4-bit digit wraps from 0 to 9 on decrement. A loaded count of 0 lasts 10000 ticks in BCD and 65536 in binary.
- R10: The latch command (access 00) copies the count into a holding register. Reads return that copy until all bytes of the access mode have been read. A second latch command before then is ignored.
- R11: In low-then-high access, successive reads alternate low byte then high byte. A control word restarts both the read and the write byte sequence at the low byte.
- R12: Mode codes 110 and 111 act as 010 and 011. After reset all outputs are low, counts are zero, and each channel is in mode 000, binary, with low-then-high access.
- R13: An output changes only in the cycle after a count-clock rising edge, a gate change or a bus write. Bus reads never move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (advances read sequencing) |
| addr | input | 2 | Bus address: 0..2 channel data, 3 control |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, valid in the cycle rd_en is high |
| ch_clk | input | 3 | Per-channel count clock, rising edge counts |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel output |

## Verification
Assertions check four things on every cycle:
- the output level forced by each control word
- the reset output state
- zero reads from the control address
- that an output stays still unless a count-clock edge, gate change or bus write preceded it

Only the bench's scenarios can show the timing of each mode against the count. For every mode it sweeps several counts tick by tick, and it also covers odd square-wave counts, retriggering, gate suspension, BCD digit borrowing and the full BCD zero count. It also shows the latch and byte-sequencing behaviour, which depends on the order of reads and writes.

// File: rtl/trio_timer.sv
module trio_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] ch_clk,
  input  logic [2:0] ch_gate,
  output logic [2:0] ch_out
);
  localparam int NCH = 3;

  function automatic logic [15:0] dec1(input logic [15:0] v, input logic b);
    logic [15:0] r;
    logic brw;
    if (!b) return v - 16'd1;
    r = v;
    brw = 1'b1;
    for (int d = 0; d < 4; d++)
      if (brw) begin
        if (r[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
        else begin
          r[4*d +: 4] = r[4*d +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    return r;
  endfunction

  logic [7:0] rb [4];
  assign rb[3] = 8'h00;
  assign rdata = rb[addr];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [15:0] cnt, init, olat;
    logic [2:0]  md, m;
    logic [1:0]  acc;
    logic        bcd, wflip, rflip, held, pend, trig, armed, xtra, outr, loaded, ckq, gq;

    wire tick  = ch_clk[i] & ~ckq;
    wire grise = ch_gate[i] & ~gq;
    wire gon   = ch_gate[i];
    wire sel_c = wr_en && addr == 2'd3 && wdata[7:6] == 2'(i);
    wire sel_w = wr_en && addr == 2'(i);
    wire sel_r = rd_en && addr == 2'(i);
    wire [15:0] nxt  = dec1(cnt, bcd);
    wire [15:0] nxt2 = dec1(nxt, bcd);
    wire [15:0] even = {init[15:1], 1'b0};
    wire [15:0] src  = held ? olat : cnt;

    assign m = (md[2] & md[1]) ? {1'b0, md[1:0]} : md;
    assign rb[i] = (acc == 2'd2 || (acc == 2'd3 && rflip)) ? src[15:8] : src[7:0];
    assign ch_out[i] = outr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0; init <= '0; olat <= '0;
        md <= '0; acc <= 2'd3; bcd <= 1'b0;
        wflip <= 1'b0; rflip <= 1'b0; held <= 1'b0; pend <= 1'b0;
        trig <= 1'b0; armed <= 1'b0; xtra <= 1'b0; outr <= 1'b0;
        loaded <= 1'b0; ckq <= 1'b0; gq <= 1'b0;
      end else begin
        ckq <= ch_clk[i];
        gq  <= ch_gate[i];

        if (grise && loaded) begin
          if (m == 3'd1 || m == 3'd5) trig <= 1'b1;
          if (m == 3'd2 || m == 3'd3) pend <= 1'b1;
        end
        if (!gon && (m == 3'd2 || m == 3'd3)) outr <= 1'b1;

        if (tick && loaded) begin
          case (m)
            3'd0: if (gon) begin
              if (pend) begin
                cnt <= init; pend <= 1'b0;
              end else begin
                cnt <= nxt;
                if (cnt == 16'd1) outr <= 1'b1;
              end
            end
            3'd1, 3'd5: begin
              if (trig) begin
                cnt <= init; trig <= 1'b0; armed <= 1'b1;
                outr <= (m == 3'd5);
              end else begin
                cnt <= nxt;
                if (m == 3'd5 && !outr) outr <= 1'b1;
                if (armed && cnt == 16'd1) begin
                  armed <= 1'b0;
                  outr <= (m == 3'd1);
                end
              end
            end
            3'd2: if (gon) begin
              if (pend || cnt == 16'd1) begin
                cnt <= init; pend <= 1'b0; outr <= 1'b1;
              end else begin
                cnt <= nxt;
                if (cnt == 16'd2) outr <= 1'b0;
              end
            end
            3'd3: if (gon) begin
              if (pend) begin
                cnt <= even; outr <= 1'b1; xtra <= 1'b0; pend <= 1'b0;
              end else if (xtra) begin
                xtra <= 1'b0; outr <= 1'b0; cnt <= even;
              end else if (cnt == 16'd2) begin
                if (outr && init[0]) begin
                  xtra <= 1'b1; cnt <= '0;
                end else begin
                  outr <= ~outr; cnt <= even;
                end
              end else cnt <= nxt2;
            end
            3'd4: if (gon) begin
              if (pend) begin
                cnt <= init; pend <= 1'b0; armed <= 1'b1;
              end else begin
                cnt <= nxt;
                if (!outr) outr <= 1'b1;
                if (armed && cnt == 16'd1) begin
                  armed <= 1'b0; outr <= 1'b0;
                end
              end
            end
            default: ;
          endcase
        end

        if (sel_c) begin
          if (wdata[5:4] == 2'd0) begin
            if (!held) begin
              held <= 1'b1; olat <= cnt;
            end
          end else begin
            acc <= wdata[5:4]; md <= wdata[3:1]; bcd <= wdata[0];
            wflip <= 1'b0; rflip <= 1'b0; held <= 1'b0; loaded <= 1'b0;
            pend <= 1'b0; trig <= 1'b0; armed <= 1'b0; xtra <= 1'b0;
            outr <= (wdata[3:1] != 3'd0);
          end
        end

        if (sel_w) begin
          if (acc == 2'd1) init <= {8'h00, wdata};
          else if (acc == 2'd2) init <= {wdata, 8'h00};
          else if (!wflip) init[7:0] <= wdata;
          else init[15:8] <= wdata;
          if (acc == 2'd3) wflip <= ~wflip;
          if (acc != 2'd3 || wflip) begin
            loaded <= 1'b1;
            trig <= 1'b0;
            if (m == 3'd0 || m == 3'd2 || m == 3'd3 || m == 3'd4) pend <= 1'b1;
            if (m == 3'd0) outr <= 1'b0;
          end
        end

        if (sel_r) begin
          if (acc == 2'd3) rflip <= ~rflip;
          if (held && (acc != 2'd3 || rflip)) held <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [2:0] ch_clk,
  input logic [2:0] ch_gate,
  input logic [2:0] ch_out
);
  a_r12_reset_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ch_out == 3'b000);

  a_r1_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> rdata == 8'h00);

  for (genvar c = 0; c < 3; c++) begin : g_c
    a_r3_mode0_word_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(c) && wdata[5:4] != 2'd0 && wdata[3:1] == 3'd0)
      |=> !ch_out[c]);

    a_r3_other_word_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(c) && wdata[5:4] != 2'd0 && wdata[3:1] != 3'd0)
      |=> ch_out[c]);

    a_r13_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ch_clk[c] && !$past(ch_clk[c])) && ch_gate[c] == $past(ch_gate[c]) && !wr_en)
      |=> $stable(ch_out[c]));
  end
endmodule

bind trio_timer trio_timer_chk u_chk (.*);

// File: tb/sim_trio_timer.sv
module sim_trio_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ch_clk = '0, ch_gate = '0;
  logic [2:0] ch_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trio_timer u0 (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
                 .ch_clk, .ch_gate, .ch_out);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int c);
    @(negedge clk); ch_clk[c] = 1'b1;
    @(negedge clk); ch_clk[c] = 1'b0;
  endtask

  task automatic gate(input int c, input logic v);
    @(negedge clk); ch_gate[c] = v;
    @(negedge clk);
  endtask

  task automatic setup(input int c, input logic [7:0] cw, input int n);
    wr(2'd3, cw); wr(2'(c), 8'(n)); wr(2'(c), 8'(n >> 8));
  endtask

  function automatic int tobcd(input int v);
    return ((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 | ((v / 10) % 10) << 4 | (v % 10);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    logic [2:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset outputs", ch_out, 0);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R12 reset count", {hi, lo}, 0);
    rd(2'd3, lo);
    chk("R1 control read zero", lo, 0);

    ch_gate = 3'b101;
    // R3 mode 0 sweep
    for (int n = 1; n <= 6; n++) begin
      setup(0, 8'h30, n);
      chk("R3 low before load", ch_out[0], 0);
      for (int k = 0; k <= n + 1; k++) begin
        pulse(0);
        chk("R3 one-shot", ch_out[0], int'(k >= n));
      end
    end
    // R3 gate suspends
    setup(0, 8'h30, 3);
    pulse(0);
    gate(0, 1'b0);
    repeat (5) pulse(0);
    chk("R3 gate low holds", ch_out[0], 0);
    gate(0, 1'b1);
    pulse(0); pulse(0);
    chk("R3 resume low", ch_out[0], 0);
    pulse(0);
    chk("R3 resume high", ch_out[0], 1);

    // R5 mode 2 sweep
    for (int n = 2; n <= 5; n++) begin
      setup(0, 8'h34, n);
      for (int k = 0; k <= 2 * n + 1; k++) begin
        pulse(0);
        chk("R5 rate", ch_out[0], int'((k % n) != n - 1));
      end
    end
    // R12 code 110 acts as rate generator
    setup(0, 8'h3C, 3);
    for (int k = 0; k <= 7; k++) begin
      pulse(0);
      chk("R12 mode6 as rate", ch_out[0], int'((k % 3) != 2));
    end
    // R5 gate behaviour
    setup(0, 8'h34, 3);
    pulse(0); pulse(0); pulse(0);
    chk("R5 low at N-1", ch_out[0], 0);
    gate(0, 1'b0);
    chk("R5 gate low forces high", ch_out[0], 1);
    gate(0, 1'b1);
    pulse(0); pulse(0);
    chk("R5 reload after gate", ch_out[0], 1);
    pulse(0);
    chk("R5 reload period", ch_out[0], 0);

    // R6 mode 3 sweep
    for (int n = 2; n <= 7; n++) begin
      setup(0, 8'h36, n);
      for (int k = 0; k <= 2 * n + 1; k++) begin
        pulse(0);
        chk("R6 square", ch_out[0], int'((k % n) < (n + 1) / 2));
      end
    end
    setup(0, 8'h3E, 4);
    for (int k = 0; k <= 9; k++) begin
      pulse(0);
      chk("R12 mode7 as square", ch_out[0], int'((k % 4) < 2));
    end

    // R7 mode 4 sweep
    for (int n = 1; n <= 5; n++) begin
      setup(0, 8'h38, n);
      for (int k = 0; k <= n + 2; k++) begin
        pulse(0);
        chk("R7 sw strobe", ch_out[0], int'(k != n));
      end
    end

    // R4 mode 1 sweep
    for (int n = 1; n <= 5; n++) begin
      gate(1, 1'b0);
      setup(1, 8'h72, n);
      gate(1, 1'b1);
      for (int k = 0; k <= n + 1; k++) begin
        pulse(1);
        chk("R4 retrig one-shot", ch_out[1], int'(k >= n));
      end
    end
    gate(1, 1'b0);
    setup(1, 8'h72, 4);
    gate(1, 1'b1);
    pulse(1); pulse(1); pulse(1);
    gate(1, 1'b0); gate(1, 1'b1);
    pulse(1);
    repeat (3) pulse(1);
    chk("R4 retrigger restarts", ch_out[1], 0);
    pulse(1);
    chk("R4 retrigger expiry", ch_out[1], 1);

    // R8 mode 5 sweep
    for (int n = 1; n <= 5; n++) begin
      gate(2, 1'b0);
      setup(2, 8'hBA, n);
      pulse(2);
      chk("R8 no start without gate", ch_out[2], 1);
      gate(2, 1'b1);
      for (int k = 0; k <= n + 1; k++) begin
        pulse(2);
        chk("R8 hw strobe", ch_out[2], int'(k != n));
      end
    end

    // R2 access modes
    setup(0, 8'h30, 3);
    wr(2'd3, 8'h20); wr(2'd0, 8'h01);
    pulse(0); pulse(0);
    rd(2'd0, hi);
    chk("R2 high-only read", hi, 8'h00);
    wr(2'd3, 8'h30);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R2 high-only write zeroes low", {hi, lo}, 16'h00FF);
    wr(2'd3, 8'h10); wr(2'd0, 8'h05);
    pulse(0);
    wr(2'd3, 8'h30);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R2 low-only write zeroes high", {hi, lo}, 16'h0005);
    wr(2'd3, 8'h30); wr(2'd0, 8'h03);
    repeat (4) pulse(0);
    chk("R2 no load after low byte", ch_out[0], 0);
    rd(2'd0, lo); rd(2'd0, hi);
    chk("R2 count untouched by low byte", {hi, lo}, 16'h0005);
    wr(2'd0, 8'h00);
    pulse(0); pulse(0); pulse(0);
    chk("R2 loaded after high byte low", ch_out[0], 0);
    pulse(0);
    chk("R2 loaded after high byte high", ch_out[0], 1);

    // R10 latch, R11 sequencing, R13 reads
    gate(1, 1'b1);
    setup(1, 8'h70, 16'h1234);
    pulse(1); pulse(1); pulse(1);
    wr(2'd3, 8'h40);
    repeat (3) pulse(1);
    wr(2'd3, 8'h40);
    rd(2'd1, lo);
    pulse(1);
    rd(2'd1, hi);
    chk("R10 latched value", {hi, lo}, 16'h1232);
    rd(2'd1, lo); rd(2'd1, hi);
    chk("R10 live after release", {hi, lo}, 16'h122E);
    chk("R13 reads leave out alone", ch_out[1], 0);
    rd(2'd1, lo);
    wr(2'd3, 8'h70);
    rd(2'd1, hi);
    chk("R11 control restarts at low", hi, 8'h2E);

    // R1 channel code 11 ignored
    snap = ch_out;
    wr(2'd3, 8'hF6);
    wr(2'd3, 8'hF0);
    chk("R1 channel 11 ignored", ch_out, snap);

    // R9 BCD
    setup(2, 8'hB1, 16'h0100);
    pulse(2);
    for (int k = 0; k <= 14; k++) begin
      rd(2'd2, lo); rd(2'd2, hi);
      chk("R9 bcd count", {hi, lo}, tobcd(100 - k));
      pulse(2);
    end
    setup(2, 8'hB1, 0);
    pulse(2);
    repeat (9999) pulse(2);
    chk("R9 bcd zero not yet", ch_out[2], 0);
    pulse(2);
    chk("R9 bcd zero is 10000", ch_out[2], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule